// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the byte a NOR-style flash device returns when the host reads it while an internal program or erase algorithm is running. The host tells the block which operation is active, which address is being programmed, and bit 7 of the byte being written. A per-sector flag vector marks the sectors that are being erased or whose erase is suspended. From these inputs the block builds a status byte on each read. Bit 7 is a polling bit that reflects the written data. Bit 6 toggles on reads from any address. Bit 2 toggles only when the read falls inside a flagged sector. When no operation is active, reads return the contents of a single stand-in storage register.

A read is one rising edge of the read strobe. The block registers the result, so the data and a one-cycle valid pulse appear one clock after the edge is sampled. Each toggle bit is a flip-flop that inverts on every read for which its toggle condition holds and keeps its value otherwise. The returned byte carries the value the flip-flop takes on that read. Returning to idle clears both flip-flops, so the first read of a new operation shows a 1 on each toggle bit that advances.

Top module: `fstat_gen`

## Requirements
- R1: While reset is held and right after it, rd_valid is 0 and rd_data is all zeros.
- R2: A read happens only on a rising edge of rd_stb. rd_valid is 1 for exactly the one cycle after the edge is sampled, and holding the strobe high produces no further read. In idle mode (code 0) the read returns the storage register, which is loaded by arr_we with arr_wdata.
- R3: In program mode (code 1), bit 7 is the complement of pgm_d7, bit 2 is 1, and bits 5, 4, 3, 1 and 0 are 0.
- R4: In program, erase and suspend-program modes, bit 6 inverts on every read from any address. The first read after idle returns 1.
- R5: In erase mode (code 2), bit 7 is 0. Bit 2 inverts on reads whose sector (the top SECT_BITS address bits) has its erase_sect flag set. A read from an unflagged sector returns bit 2 unchanged and does not advance it.
- R6: In suspend-read mode (code 3), a read from a flagged sector returns bit 7 = 1 and bit 6 = 1, inverts bit 2, and leaves the bit 6 flip-flop unchanged.
- R7: In suspend-read mode, a read from an unflagged sector returns the storage register.
- R8: In suspend-program mode (code 4), bit 7 is the complement of pgm_d7. A read of pgm_addr returns bit 2 = 1 without advancing it. Reads from other addresses in flagged sectors invert bit 2.
- R9: Mode codes 5 to 7 act as idle: reads return the storage register, and both toggle flip-flops are cleared.
- R10: The toggle flip-flops keep their state across changes between non-idle modes, such as erase to suspend-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Operation code: 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program |
| rd_stb | input | 1 | Read strobe; each rising edge is one read |
| rd_addr | input | ADDR_W | Read address |
| pgm_addr | input | ADDR_W | Address being programmed |
| pgm_d7 | input | 1 | Bit 7 of the byte being programmed |
| erase_sect | input | 2**SECT_BITS | One flag per sector, set while that sector is erasing or erase-suspended |
| arr_we | input | 1 | Load strobe for the storage register |
| arr_wdata | input | DATA_W | Data loaded into the storage register |
| rd_data | output | DATA_W | Registered read result |
| rd_valid | output | 1 | One-cycle pulse marking a new rd_data |

## Verification
The bench builds the block with 10-bit addresses, two sector bits (four sectors) and an 8-bit data bus. With these values, sector boundaries lie 0x100 apart, so a single pattern can mix reads from flagged sectors, unflagged sectors and the programmed address. The scenarios run in sequence without returning to idle wherever possible: erase, then suspend-read, then suspend-program. This makes the carried toggle state (R10) visible in the expected bytes. A final pass with an undefined mode code confirms that both toggles clear.

// File: rtl/fstat_pkg.sv
package fstat_pkg;

   typedef enum logic [2:0] {
      FM_IDLE     = 3'd0,
      FM_PGM      = 3'd1,
      FM_ERASE    = 3'd2,
      FM_SUSP_RD  = 3'd3,
      FM_SUSP_PGM = 3'd4
   } fmode_e;

   localparam int POLL_BIT     = 7;
   localparam int TGL_BIT      = 6;
   localparam int SECT_TGL_BIT = 2;

   typedef struct packed {
      logic idle;
      logic pgm;
      logic erase;
      logic susp_rd;
      logic susp_pgm;
   } mode_dec_t;

endpackage

// File: rtl/fstat_rd_edge.sv
module fstat_rd_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   output logic fire
);
   logic stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= stb;
   end

   assign fire = stb & ~stb_q;
endmodule

// File: rtl/fstat_mode_dec.sv
module fstat_mode_dec
   import fstat_pkg::*;
(
   input  logic [2:0] mode_code,
   output mode_dec_t  dec
);
   always_comb begin
      dec = '0;
      case (mode_code)
         FM_PGM:      dec.pgm      = 1'b1;
         FM_ERASE:    dec.erase    = 1'b1;
         FM_SUSP_RD:  dec.susp_rd  = 1'b1;
         FM_SUSP_PGM: dec.susp_pgm = 1'b1;
         default:     dec.idle     = 1'b1;
      endcase
   end
endmodule

// File: rtl/fstat_sector_hit.sv
module fstat_sector_hit #(
   parameter int SECT_BITS = 3,
   localparam int NSECT = 1 << SECT_BITS
) (
   input  logic [SECT_BITS-1:0] sect_idx,
   input  logic [NSECT-1:0]     erase_sect,
   output logic                 hit
);
   generate
      if (NSECT == 2) begin : g_pair
         assign hit = sect_idx[0] ? erase_sect[1] : erase_sect[0];
      end else begin : g_index
         assign hit = erase_sect[sect_idx];
      end
   endgenerate
endmodule

// File: rtl/fstat_toggle.sv
module fstat_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic q_next
);
   logic q;

   assign q_next = adv ? ~q : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else          q <= q_next;
   end
endmodule

// File: rtl/fstat_status_mux.sv
module fstat_status_mux
   import fstat_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  mode_dec_t          md,
   input  logic               in_sect,
   input  logic               at_pgm,
   input  logic               pgm_d7,
   input  logic               t6n,
   input  logic               t2n,
   input  logic [DATA_W-1:0]  arr_q,
   output logic [DATA_W-1:0]  word
);
   logic poll, tgl, st2, use_arr;
   logic [DATA_W-1:0] status;

   always_comb begin
      use_arr = md.idle | (md.susp_rd & ~in_sect);
      if (md.pgm | md.susp_pgm) poll = ~pgm_d7;
      else if (md.susp_rd)      poll = 1'b1;
      else                      poll = 1'b0;
      tgl = md.susp_rd ? 1'b1 : t6n;
      st2 = (md.pgm | (md.susp_pgm & at_pgm)) ? 1'b1 : t2n;
   end

   genvar b;
   generate
      for (b = 0; b < DATA_W; b++) begin : g_bit
         if (b == POLL_BIT) begin : g_poll
            assign status[b] = poll;
         end else if (b == TGL_BIT) begin : g_tgl
            assign status[b] = tgl;
         end else if (b == SECT_TGL_BIT) begin : g_st2
            assign status[b] = st2;
         end else begin : g_zero
            assign status[b] = 1'b0;
         end
      end
   endgenerate

   assign word = use_arr ? arr_q : status;
endmodule

// File: rtl/fstat_gen.sv
module fstat_gen
   import fstat_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int SECT_BITS = 3,
   localparam int NSECT = 1 << SECT_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] pgm_addr,
   input  logic              pgm_d7,
   input  logic [NSECT-1:0]  erase_sect,
   input  logic              arr_we,
   input  logic [DATA_W-1:0] arr_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("fstat_gen: DATA_W must be at least 8");
      end
      if (SECT_BITS < 1 || SECT_BITS > ADDR_W) begin : g_bad_sect
         $error("fstat_gen: SECT_BITS must lie in 1..ADDR_W");
      end
   endgenerate

   logic              fire;
   mode_dec_t         md;
   logic              in_sect, at_pgm;
   logic              adv6, adv2, t6n, t2n;
   logic [DATA_W-1:0] arr_q, word;

   fstat_rd_edge u_edge (.clk(clk), .rst_n(rst_n), .stb(rd_stb), .fire(fire));

   fstat_mode_dec u_dec (.mode_code(mode), .dec(md));

   fstat_sector_hit #(.SECT_BITS(SECT_BITS)) u_hit (
      .sect_idx  (rd_addr[ADDR_W-1 -: SECT_BITS]),
      .erase_sect(erase_sect),
      .hit       (in_sect)
   );

   assign at_pgm = (rd_addr == pgm_addr);
   assign adv6   = fire & (md.pgm | md.erase | md.susp_pgm);
   assign adv2   = fire & in_sect & (md.erase | md.susp_rd | (md.susp_pgm & ~at_pgm));

   fstat_toggle u_tgl6 (.clk(clk), .rst_n(rst_n), .clr(md.idle), .adv(adv6), .q_next(t6n));
   fstat_toggle u_tgl2 (.clk(clk), .rst_n(rst_n), .clr(md.idle), .adv(adv2), .q_next(t2n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      arr_q <= '0;
      else if (arr_we) arr_q <= arr_wdata;
   end

   fstat_status_mux #(.DATA_W(DATA_W)) u_mux (
      .md(md), .in_sect(in_sect), .at_pgm(at_pgm), .pgm_d7(pgm_d7),
      .t6n(t6n), .t2n(t2n), .arr_q(arr_q), .word(word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= fire;
         if (fire) rd_data <= word;
      end
   end
endmodule

// File: rtl/fstat_gen_chk.sv
module fstat_gen_chk #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int SECT_BITS = 3,
   localparam int NSECT = 1 << SECT_BITS
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [ADDR_W-1:0] pgm_addr,
   input logic              pgm_d7,
   input logic [NSECT-1:0]  erase_sect,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid
);
   logic flag_hit;
   assign flag_hit = erase_sect[rd_addr[ADDR_W-1 -: SECT_BITS]];

   assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_valid_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_stb));

   assert_pgm_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(mode) == 3'd1) |-> (rd_data[7] != $past(pgm_d7) && rd_data[2]));

   assert_erase_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(mode) == 3'd2) |-> !rd_data[7]);

   assert_susp_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(mode) == 3'd3 && $past(flag_hit)) |-> (rd_data[7] && rd_data[6]));

   assert_susp_pgm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(mode) == 3'd4 && $past(rd_addr == pgm_addr))
         |-> (rd_data[2] && rd_data[7] != $past(pgm_d7)));
endmodule

bind fstat_gen fstat_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .rd_stb(rd_stb), .rd_addr(rd_addr),
   .pgm_addr(pgm_addr), .pgm_d7(pgm_d7), .erase_sect(erase_sect),
   .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/fstat_gen_bench.sv
module fstat_gen_bench;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int SB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode = 3'd0;
   logic          rd_stb = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [AW-1:0] pgm_addr = '0;
   logic          pgm_d7 = 1'b0;
   logic [3:0]    erase_sect = '0;
   logic          arr_we = 1'b0;
   logic [DW-1:0] arr_wdata = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   fstat_gen #(.ADDR_W(AW), .DATA_W(DW), .SECT_BITS(SB)) u_fstat_gen (
      .clk(clk), .rst_n(rst_n), .mode(mode), .rd_stb(rd_stb), .rd_addr(rd_addr),
      .pgm_addr(pgm_addr), .pgm_d7(pgm_d7), .erase_sect(erase_sect),
      .arr_we(arr_we), .arr_wdata(arr_wdata), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      logic v;
      logic [DW-1:0] d;
      @(negedge clk);
      rd_addr = a;
      rd_stb  = 1'b1;
      @(negedge clk);
      v = rd_valid;
      d = rd_data;
      rd_stb = 1'b0;
      chk({req, " valid"}, {7'd0, v}, 8'd1);
      chk(req, d, exp);
      @(negedge clk);
   endtask

   task automatic load_arr(input logic [DW-1:0] v);
      @(negedge clk);
      arr_we = 1'b1;
      arr_wdata = v;
      @(negedge clk);
      arr_we = 1'b0;
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk);
      mode = m;
   endtask

   task automatic t_reset;
      #1;
      chk("R1 valid in reset", {7'd0, rd_valid}, 8'd0);
      chk("R1 data in reset", rd_data, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", {7'd0, rd_valid}, 8'd0);
      chk("R1 data after reset", rd_data, 8'h00);
   endtask

   task automatic t_idle;
      load_arr(8'hA5);
      rd("R2 idle read", 10'h155, 8'hA5);
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      chk("R2 held first valid", {7'd0, rd_valid}, 8'd1);
      arr_we = 1'b1;
      arr_wdata = 8'h3C;
      @(negedge clk);
      arr_we = 1'b0;
      chk("R2 held no second read", {7'd0, rd_valid}, 8'd0);
      @(negedge clk);
      chk("R2 held data kept", rd_data, 8'hA5);
      rd_stb = 1'b0;
      load_arr(8'hA5);
   endtask

   task automatic t_program;
      pgm_d7 = 1'b1;
      set_mode(3'd1);
      rd("R3 R4 pgm d7=1 r1", 10'h010, 8'h44);
      rd("R3 R4 pgm d7=1 r2", 10'h300, 8'h04);
      pgm_d7 = 1'b0;
      rd("R3 R4 pgm d7=0 r3", 10'h200, 8'hC4);
      set_mode(3'd0);
   endtask

   task automatic t_erase;
      erase_sect = 4'b0010;
      set_mode(3'd2);
      rd("R5 R4 erase in-sector", 10'h120, 8'h44);
      rd("R5 erase out-of-sector holds", 10'h020, 8'h04);
      rd("R5 erase in-sector again", 10'h1FF, 8'h40);
   endtask

   task automatic t_susp_rd;
      set_mode(3'd3);
      rd("R6 R10 susp rd in-sector", 10'h130, 8'hC4);
      rd("R7 susp rd out-of-sector", 10'h330, 8'hA5);
      rd("R6 susp rd in-sector again", 10'h101, 8'hC0);
   endtask

   task automatic t_susp_pgm;
      pgm_addr = 10'h020;
      pgm_d7 = 1'b0;
      set_mode(3'd4);
      rd("R8 susp pgm at pgm_addr", 10'h020, 8'h84);
      rd("R8 susp pgm flagged sector", 10'h140, 8'hC4);
      rd("R8 susp pgm flagged sector again", 10'h141, 8'h80);
      rd("R8 susp pgm at pgm_addr no advance", 10'h020, 8'hC4);
      rd("R8 susp pgm unflagged holds", 10'h030, 8'h80);
   endtask

   task automatic t_undef;
      set_mode(3'd6);
      rd("R9 undefined mode reads array", 10'h140, 8'hA5);
      set_mode(3'd2);
      rd("R9 toggles cleared by undefined mode", 10'h150, 8'h44);
      set_mode(3'd0);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_program();
      t_erase();
      t_susp_rd();
      t_susp_pgm();
      t_undef();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired got=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule